// File: doc/BRIEF.md
# Field-Synchronized Video Stream Gate

This block sits between a clocked video receiver and a packetized video sink and decides which whole fields are allowed through. Software sets or clears a single enable bit. The block does not act on a change straight away. It applies the change only when a new field begins, and only if a field-order policy allows that field parity to open the stream or allows the previous field to close it. A status bit reports whether the gate is currently passing fields. This bit can change only on a field boundary.

Each sample that passes is re-emitted as a packet stream. The first active sample of a field carries a start marker and the last carries an end marker. The last sample of a field is only known once the next field starts, so the gate holds one sample back. A field's final sample is therefore emitted in the cycle after the next field-start edge. For progressive input, every passed frame is labelled as an even (F0) field, whatever parity the source reports.

Top module: `videoFieldGate`

## Requirements
- R1: After reset, the running status and the control readback are 0, and no sample is emitted until the control bit is written to 1.
- R2: A write with `ctrlWrEn` high loads `ctrlWrData` into the control bit, and `ctrlBit` returns the written value from the next cycle.
- R3: `statusRunning` changes only on the clock edge of a cycle in which `inFieldStart` is 1. A request written in the middle of a field leaves the status unchanged until the next field start.
- R4: With interlaced input (`interlaced`=1) and order code 1 (odd field first), output opens only on a field whose parity bit is 1. After a stop request, output closes only at a boundary whose previous passed field had parity 0. A stop requested during an odd field therefore lets the following even field through, so the passed fields run 1,0,...,1,0.
- R5: With interlaced input and order code 0 (even field first), output opens only on a parity-0 field and closes only after a passed parity-1 field.
- R6: With interlaced input and order code 2 or 3 (either field), output opens on a field of either parity and closes at the first field boundary after the stop request.
- R7: With progressive input (`interlaced`=0) and order code 0 or 2, every frame is eligible to open or close the stream, and every passed frame is emitted with `outField`=0, whatever `inFieldParity` says.
- R8: With progressive input and order code 1, no sample is ever emitted and `statusRunning` stays 0.
- R9: If the control bit returns to the current running state before the next field start, the pending request is dropped, the status does not change and the next field is handled as if no request had been made.
- R10: In each passed field, every active sample is emitted once and in input order. `outSop` is 1 only on the first sample of the field and `outEop` only on the last, and both are 1 on a one-sample field. The last sample is emitted in the cycle after the next `inFieldStart` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 1 | Enable value to write |
| ctrlBit | output | 1 | Readback of the enable bit |
| statusRunning | output | 1 | 1 while fields are being passed |
| interlaced | input | 1 | 1 = interlaced source, 0 = progressive |
| fieldOrder | input | 2 | 0 even first, 1 odd first, 2/3 either |
| inValid | input | 1 | Active-video sample present |
| inFieldStart | input | 1 | First cycle of a new field or frame |
| inFieldParity | input | 1 | Parity of the field starting (valid with inFieldStart) |
| inData | input | DATA_W | Sample value |
| outValid | output | 1 | Output sample present |
| outSop | output | 1 | First sample of a passed field |
| outEop | output | 1 | Last sample of a passed field |
| outField | output | 1 | Parity label of the passed field |
| outData | output | DATA_W | Output sample value |

## Verification
The embedded properties watch on every cycle that the running status moves only at a field start, that a wrong-parity field can never open the stream under the two fixed orders, that progressive odd-first mode never starts, and that an end marker appears only just after a field start. The scenarios are needed to show which fields reach the output. They cover the parity sequence of the passed fields, the extra closing field that a late stop request lets through, the cancelled requests, and the sample counts, order and markers of short and one-sample fields.

// File: rtl/videoGatePkg.sv
package videoGatePkg;

  localparam logic [1:0] ORDER_EVEN_FIRST = 2'd0;
  localparam logic [1:0] ORDER_ODD_FIRST  = 2'd1;

  // Per-boundary strobes from the control to the datapath
  typedef struct packed {
    logic fieldBegin;  // a new field starts this cycle
    logic passField;   // the field now starting goes to the output
    logic fieldTag;    // parity label to attach to that field
  } gateStrobe_t;

  // Open the stream on this effective parity?
  function automatic logic startAllowed(input logic isInterlaced,
                                        input logic [1:0] order,
                                        input logic effParity);
    logic eitherOrder;
    eitherOrder = order[1];
    if (!isInterlaced && order == ORDER_ODD_FIRST) return 1'b0;
    if (eitherOrder) return 1'b1;
    return effParity == (order == ORDER_ODD_FIRST);
  endfunction

  // Close the stream after a passed field of this parity?
  function automatic logic endAllowed(input logic isInterlaced,
                                      input logic [1:0] order,
                                      input logic lastTag);
    if (!isInterlaced || order[1]) return 1'b1;
    return lastTag == (order == ORDER_EVEN_FIRST);
  endfunction

endpackage

// File: rtl/videoGateCtrl.sv
module videoGateCtrl
  import videoGatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic        ctrlWrData,
  input  logic        interlaced,
  input  logic [1:0]  fieldOrder,
  input  logic        inFieldStart,
  input  logic        inFieldParity,
  output logic        ctrlBit,
  output logic        statusRunning,
  output gateStrobe_t strobe
);

  logic enableReg;
  logic running;
  logic lastTag;
  logic effParity;
  logic blockedMode;
  logic canStart;
  logic canEnd;
  logic passNow;
  logic runNext;

  assign effParity   = interlaced ? inFieldParity : 1'b0;
  assign blockedMode = !interlaced && (fieldOrder == ORDER_ODD_FIRST);
  assign canStart    = startAllowed(interlaced, fieldOrder, effParity);
  assign canEnd      = endAllowed(interlaced, fieldOrder, lastTag);

  // Decision taken at each field boundary
  always_comb begin
    passNow = 1'b0;
    runNext = running;
    if (inFieldStart) begin
      if (!running) begin
        if (enableReg && canStart) begin
          runNext = 1'b1;
          passNow = 1'b1;
        end
      end else if (blockedMode || (!enableReg && canEnd)) begin
        runNext = 1'b0;
      end else begin
        passNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      running   <= 1'b0;
      lastTag   <= 1'b0;
    end else begin
      if (ctrlWrEn) enableReg <= ctrlWrData;
      running <= runNext;
      if (passNow) lastTag <= effParity;
    end
  end

  assign ctrlBit           = enableReg;
  assign statusRunning     = running;
  assign strobe.fieldBegin = inFieldStart;
  assign strobe.passField  = passNow;
  assign strobe.fieldTag   = effParity;

  AST_STATUS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !inFieldStart |=> $stable(statusRunning)); // R3

  AST_ODD_FIRST_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (inFieldStart && !statusRunning && interlaced &&
     fieldOrder == ORDER_ODD_FIRST && !inFieldParity) |=> !statusRunning); // R4

  AST_EVEN_FIRST_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (inFieldStart && !statusRunning && interlaced &&
     fieldOrder == ORDER_EVEN_FIRST && inFieldParity) |=> !statusRunning); // R5

  AST_PROGRESSIVE_ODD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!statusRunning && !interlaced && fieldOrder == ORDER_ODD_FIRST)
      |=> !statusRunning); // R8

endmodule

// File: rtl/videoGateDatapath.sv
module videoGateDatapath
  import videoGatePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              outField,
  output logic [DATA_W-1:0] outData
);

  logic              passReg;
  logic              tagReg;
  logic              sopNext;
  logic              holdValid;
  logic              holdSop;
  logic              holdTag;
  logic [DATA_W-1:0] holdData;

  // One sample is held back so the field's last sample can be marked
  always_ff @(posedge clk) begin
    if (!rstN) begin
      passReg   <= 1'b0;
      tagReg    <= 1'b0;
      sopNext   <= 1'b0;
      holdValid <= 1'b0;
      holdSop   <= 1'b0;
      holdTag   <= 1'b0;
      holdData  <= '0;
      outValid  <= 1'b0;
      outSop    <= 1'b0;
      outEop    <= 1'b0;
      outField  <= 1'b0;
      outData   <= '0;
    end else begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      if (strobe.fieldBegin) begin
        if (holdValid) begin
          outValid <= 1'b1;
          outSop   <= holdSop;
          outEop   <= 1'b1;
          outField <= holdTag;
          outData  <= holdData;
        end
        holdValid <= 1'b0;
        passReg   <= strobe.passField;
        tagReg    <= strobe.fieldTag;
        sopNext   <= 1'b1;
        if (inValid && strobe.passField) begin
          holdValid <= 1'b1;
          holdSop   <= 1'b1;
          holdTag   <= strobe.fieldTag;
          holdData  <= inData;
          sopNext   <= 1'b0;
        end
      end else if (inValid && passReg) begin
        if (holdValid) begin
          outValid <= 1'b1;
          outSop   <= holdSop;
          outEop   <= 1'b0;
          outField <= holdTag;
          outData  <= holdData;
        end
        holdValid <= 1'b1;
        holdSop   <= sopNext;
        holdTag   <= tagReg;
        holdData  <= inData;
        sopNext   <= 1'b0;
      end
    end
  end

  AST_EOP_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEop) |-> $past(strobe.fieldBegin)); // R10

  AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outSop || outEop) |-> outValid); // R10

endmodule

// File: rtl/videoFieldGate.sv
module videoFieldGate
  import videoGatePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrData,
  output logic              ctrlBit,
  output logic              statusRunning,
  input  logic              interlaced,
  input  logic [1:0]        fieldOrder,
  input  logic              inValid,
  input  logic              inFieldStart,
  input  logic              inFieldParity,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              outField,
  output logic [DATA_W-1:0] outData
);

  gateStrobe_t strobe;

  videoGateCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlWrEn     (ctrlWrEn),
    .ctrlWrData   (ctrlWrData),
    .interlaced   (interlaced),
    .fieldOrder   (fieldOrder),
    .inFieldStart (inFieldStart),
    .inFieldParity(inFieldParity),
    .ctrlBit      (ctrlBit),
    .statusRunning(statusRunning),
    .strobe       (strobe)
  );

  videoGateDatapath #(.DATA_W(DATA_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outSop  (outSop),
    .outEop  (outEop),
    .outField(outField),
    .outData (outData)
  );

endmodule

// File: tb/videoFieldGate_bench.sv
module videoFieldGate_bench;

  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ctrlWrEn = 1'b0;
  logic              ctrlWrData = 1'b0;
  logic              ctrlBit;
  logic              statusRunning;
  logic              interlaced = 1'b1;
  logic [1:0]        fieldOrder = 2'd2;
  logic              inValid = 1'b0;
  logic              inFieldStart = 1'b0;
  logic              inFieldParity = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic              outSop;
  logic              outEop;
  logic              outField;
  logic [DATA_W-1:0] outData;

  int checks = 0;
  int errors = 0;

  // Monitor results
  int fieldCount = 0;
  int structErr = 0;
  int dataErr = 0;
  int tagSum = 0;
  bit inPkt = 1'b0;
  int fieldTag [0:31];
  int fieldLen [0:31];
  int fieldFirst [0:31];
  int fieldLast [0:31];
  int lastData = 0;

  always #4 clk = ~clk;

  videoFieldGate #(.DATA_W(DATA_W)) u_videoFieldGate (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlBit(ctrlBit), .statusRunning(statusRunning),
    .interlaced(interlaced), .fieldOrder(fieldOrder),
    .inValid(inValid), .inFieldStart(inFieldStart),
    .inFieldParity(inFieldParity), .inData(inData),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outField(outField), .outData(outData)
  );

  always @(negedge clk) begin
    if (outValid && fieldCount < 32) begin
      if (outSop) begin
        if (inPkt) structErr++;
        inPkt = 1'b1;
        fieldTag[fieldCount]   = int'(outField);
        fieldFirst[fieldCount] = int'(outData);
        fieldLen[fieldCount]   = 0;
      end else begin
        if (!inPkt) structErr++;
        if (int'(outData) != lastData + 1) dataErr++;
      end
      lastData = int'(outData);
      fieldLen[fieldCount]++;
      fieldLast[fieldCount] = int'(outData);
      if (outEop) begin
        inPkt = 1'b0;
        tagSum += int'(outField);
        fieldCount++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input bit il, input logic [1:0] ord);
    @(negedge clk);
    rstN = 1'b0;
    interlaced = il;
    fieldOrder = ord;
    inValid = 1'b0;
    inFieldStart = 1'b0;
    ctrlWrEn = 1'b0;
    repeat (3) @(negedge clk);
    fieldCount = 0; structErr = 0; dataErr = 0; tagSum = 0; inPkt = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic writeCtrl(input bit v);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  // Field: start cycle, 2 blanking, n active, 2 blanking
  task automatic sendField(input bit par, input int n, input int base,
                           input int wrAt = -1, input bit wrVal = 1'b0,
                           input int wr2At = -1, input bit wr2Val = 1'b0);
    for (int c = 0; c < n + 5; c++) begin
      @(negedge clk);
      inFieldStart  = (c == 0);
      inFieldParity = par;
      inValid       = (c >= 3) && (c < 3 + n);
      inData        = DATA_W'(base + c - 3);
      ctrlWrEn      = (c == wrAt) || (c == wr2At);
      ctrlWrData    = (c == wr2At) ? wr2Val : wrVal;
    end
    @(negedge clk);
    inFieldStart = 1'b0;
    inValid = 1'b0;
    ctrlWrEn = 1'b0;
  endtask

  task automatic testResetAndControl;
    doReset(1'b1, 2'd2);
    @(negedge clk);
    check("R1", int'(statusRunning), 0, "status after reset");
    check("R1", int'(ctrlBit), 0, "control after reset");
    check("R1", int'(outValid), 0, "no output after reset");
    sendField(1'b0, 3, 8'h10);
    sendField(1'b1, 3, 8'h20);
    check("R1", fieldCount, 0, "fields while disabled");
    writeCtrl(1'b1);
    check("R2", int'(ctrlBit), 1, "readback after write 1");
    check("R3", int'(statusRunning), 0, "status before boundary");
    writeCtrl(1'b0);
    check("R2", int'(ctrlBit), 0, "readback after write 0");
  endtask

  task automatic testOddFirst;
    doReset(1'b1, 2'd1);
    writeCtrl(1'b1);
    sendField(1'b0, 3, 8'h10);
    check("R4", int'(statusRunning), 0, "even field must not open");
    sendField(1'b1, 3, 8'h20);
    check("R4", int'(statusRunning), 1, "odd field opens");
    sendField(1'b0, 3, 8'h30);
    sendField(1'b1, 3, 8'h40, 4, 1'b0);
    check("R3", int'(statusRunning), 1, "stop pending mid-field");
    sendField(1'b0, 3, 8'h50);
    check("R4", int'(statusRunning), 1, "closing even field still passes");
    sendField(1'b1, 3, 8'h60);
    check("R4", int'(statusRunning), 0, "stopped after even field");
    sendField(1'b0, 2, 8'h70);
    check("R4", fieldCount, 4, "passed field count");
    check("R4", fieldTag[0] * 8 + fieldTag[1] * 4 + fieldTag[2] * 2 + fieldTag[3], 10,
          "tag pattern 1,0,1,0");
    check("R4", fieldFirst[0], 8'h20, "first passed field");
    check("R4", fieldFirst[3], 8'h50, "last passed field");
  endtask

  task automatic testEvenFirst;
    doReset(1'b1, 2'd0);
    writeCtrl(1'b1);
    sendField(1'b1, 3, 8'h10);
    check("R5", int'(statusRunning), 0, "odd field must not open");
    sendField(1'b0, 3, 8'h20);
    check("R5", int'(statusRunning), 1, "even field opens");
    sendField(1'b1, 3, 8'h30);
    sendField(1'b0, 3, 8'h40, 4, 1'b0);
    sendField(1'b1, 3, 8'h50);
    check("R5", int'(statusRunning), 1, "closing odd field passes");
    sendField(1'b0, 3, 8'h60);
    check("R5", int'(statusRunning), 0, "stopped after odd field");
    sendField(1'b1, 2, 8'h70);
    check("R5", fieldCount, 4, "passed field count");
    check("R5", fieldTag[0] * 8 + fieldTag[1] * 4 + fieldTag[2] * 2 + fieldTag[3], 5,
          "tag pattern 0,1,0,1");
  endtask

  task automatic testEither;
    doReset(1'b1, 2'd2);
    writeCtrl(1'b1);
    sendField(1'b1, 3, 8'h10);
    check("R6", int'(statusRunning), 1, "opens on odd field");
    sendField(1'b0, 3, 8'h20, 4, 1'b0);
    sendField(1'b1, 3, 8'h30);
    check("R6", int'(statusRunning), 0, "closes at next boundary");
    sendField(1'b0, 2, 8'h40);
    check("R6", fieldCount, 2, "passed field count");
    check("R6", fieldTag[0] * 2 + fieldTag[1], 2, "tag pattern 1,0");
  endtask

  task automatic testProgressive;
    doReset(1'b0, 2'd0);
    writeCtrl(1'b1);
    sendField(1'b1, 3, 8'h10);
    check("R7", int'(statusRunning), 1, "progressive frame opens");
    sendField(1'b0, 3, 8'h20);
    sendField(1'b1, 3, 8'h30, 4, 1'b0);
    sendField(1'b1, 3, 8'h40);
    check("R7", int'(statusRunning), 0, "progressive stop");
    sendField(1'b0, 2, 8'h50);
    check("R7", fieldCount, 3, "passed frames");
    check("R7", tagSum, 0, "all frames tagged even");
  endtask

  task automatic testProgressiveOddFirst;
    doReset(1'b0, 2'd1);
    writeCtrl(1'b1);
    sendField(1'b1, 3, 8'h10);
    sendField(1'b0, 3, 8'h20);
    sendField(1'b1, 3, 8'h30);
    check("R8", int'(statusRunning), 0, "never starts");
    check("R8", fieldCount, 0, "nothing emitted");
  endtask

  task automatic testCancel;
    doReset(1'b1, 2'd2);
    writeCtrl(1'b1);
    sendField(1'b0, 3, 8'h10);
    sendField(1'b1, 3, 8'h20, 4, 1'b0, 6, 1'b1);
    sendField(1'b0, 3, 8'h30, 4, 1'b0);
    check("R9", int'(statusRunning), 1, "cancelled stop keeps running");
    sendField(1'b1, 3, 8'h40, 3, 1'b1, 5, 1'b0);
    check("R9", int'(statusRunning), 0, "stop after real request");
    sendField(1'b0, 3, 8'h50);
    check("R9", int'(statusRunning), 0, "cancelled start stays stopped");
    check("R9", fieldCount, 3, "fields passed");
  endtask

  task automatic testMarkers;
    doReset(1'b1, 2'd2);
    writeCtrl(1'b1);
    sendField(1'b0, 1, 8'h80);
    sendField(1'b1, 5, 8'h90);
    sendField(1'b0, 2, 8'hA0, 4, 1'b0);
    sendField(1'b1, 3, 8'hB0);
    check("R10", fieldCount, 3, "packet count");
    check("R10", fieldLen[0], 1, "one-sample field length");
    check("R10", fieldLen[1], 5, "five-sample field length");
    check("R10", fieldLen[2], 2, "two-sample field length");
    check("R10", fieldFirst[1], 8'h90, "first sample value");
    check("R10", fieldLast[1], 8'h94, "last sample value");
    check("R10", fieldFirst[0], 8'h80, "single sample value");
    check("R10", structErr, 0, "marker structure errors");
    check("R10", dataErr, 0, "sample order errors");
  endtask

  initial begin
    testResetAndControl();
    testOddFirst();
    testEvenFirst();
    testEither();
    testProgressive();
    testProgressiveOddFirst();
    testCancel();
    testMarkers();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule